// File: doc/BRIEF.md
# Compare and Reload Counter Core

This block is a 16-bit up/down counter. Two compare values and a reload value govern it. One of eight count modes decides when the counter steps and in which direction. The modes can use a primary tick, both primary edges, a tick gated by a secondary level, a two-input Gray decode, a direction taken from the secondary input, a run window that a secondary edge starts, or separate up and down carry pulses. Prescaling and source selection happen outside the block, so edges arrive as single-cycle pulses.

The counter can wrap freely or reinitialise on a successful compare. A compare is checked against the value that matches the count direction, or against the two values in turn. It can stop after one compare pass, and it can be forced to reinitialise from outside. Each compare shows up as a one-cycle pulse. Two sticky flags record wraps and compares, and a status bit holds the direction of the most recent step.

Top module: `cmp_reload_ctr`

## Requirements
- R1: After reset the count is 0x0000, both compare pulses and both sticky flags are 0, and the direction status reads 1 (up).
- R2: With `len_i`=0 the count wraps from 0xFFFF to 0x0000 going up and from 0x0000 to 0xFFFF going down, and each wrap sets `ovf_o`.
- R3: With `len_i`=1, `alt_cmp_i`=0 and the count going up, a step taken while the count equals `comp1_i` loads the reload value instead of incrementing and raises `cmp1_o` for one cycle.
- R4: With `len_i`=1, `alt_cmp_i`=0 and the count going down, a step taken while the count equals `comp2_i` loads the reload value and raises `cmp2_o` for one cycle.
- R5: With `alt_cmp_i`=1 the compare target alternates, starting at `comp1_i` after a reload: a hit on `comp1_i` pulses `cmp1_o`, a hit on `comp2_i` pulses `cmp2_o`, and the two pulses are never high together.
- R6: With `once_i`=1 the counter ignores all steps after the first successful compare. In alternating mode it stops after the `comp2_i` hit that follows the `comp1_i` hit. `ext_reload_i` releases the stop.
- R7: `mode_i` encoding: 000 never steps; 001 steps on `prim_rise_i`; 010 steps on `prim_rise_i` or `prim_fall_i`; 011 steps on `prim_rise_i` only while `sec_lvl_i` is 1. In modes 001, 010, 011 and 110 the direction is `dir_i` (0 up, 1 down).
- R8: Mode 100 decodes {`prim_lvl_i`,`sec_lvl_i`} as a Gray sequence 00→10→11→01→00 counting up, and counts down in the reverse order. A change of both inputs in one cycle is ignored.
- R9: Mode 101 steps on `prim_rise_i` with direction `dir_i` XOR `sec_lvl_i`. Mode 111 counts up on `prim_rise_i` and down on `prim_fall_i`.
- R10: In mode 110 `sec_rise_i` starts a run, and during a run `prim_rise_i` steps the counter until a compare ends the run. A further `sec_rise_i` during a run stops it when `tci_i`=0, and reloads the count while the run continues when `tci_i`=1.
- R11: The reload value is `load_i`, except when `alt_load_i`=1 and the count direction is down, in which case it is `alt_val_i`.
- R12: `up_o` takes the direction of every counted step and keeps it while no step occurs.
- R13: `ext_reload_i` loads the reload value and takes priority over a step in the same cycle.
- R14: `ovf_o` and `cmpf_o` stay high until `ovf_clr_i` or `cmpf_clr_i` clears them. `cmpf_o` sets on every successful compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Count mode |
| dir_i | input | 1 | Configured direction, 1 = down |
| len_i | input | 1 | Reinitialise on compare |
| once_i | input | 1 | Stop after compare pass |
| alt_cmp_i | input | 1 | Alternating compare targets |
| tci_i | input | 1 | Second trigger reloads (1) or stops (0) |
| alt_load_i | input | 1 | Use alternate reload value when counting down |
| prim_rise_i | input | 1 | Primary rising-edge pulse |
| prim_fall_i | input | 1 | Primary falling-edge pulse |
| prim_lvl_i | input | 1 | Primary input level |
| sec_lvl_i | input | 1 | Secondary input level |
| sec_rise_i | input | 1 | Secondary rising-edge pulse |
| comp1_i | input | 16 | Compare value 1 |
| comp2_i | input | 16 | Compare value 2 |
| load_i | input | 16 | Reload value |
| alt_val_i | input | 16 | Alternate reload value |
| ext_reload_i | input | 1 | External reload request |
| ovf_clr_i | input | 1 | Clear wrap flag |
| cmpf_clr_i | input | 1 | Clear compare flag |
| count_o | output | 16 | Counter value |
| cmp1_o | output | 1 | Compare 1 pulse |
| cmp2_o | output | 1 | Compare 2 pulse |
| ovf_o | output | 1 | Sticky wrap flag |
| cmpf_o | output | 1 | Sticky compare flag |
| up_o | output | 1 | Direction of last step, 1 = up |

## Verification
Every output is a register, so the effect of inputs sampled at one clock edge shows up right after that edge. This covers the new count, the compare pulses, flag changes and the direction bit. The driver changes inputs on the falling edge and queues the expected result for that cycle. The monitor pops the entry one time unit after the following rising edge, so each expectation is compared exactly one cycle after its stimulus. Pulse outputs are expected low again in the next queued cycle.

// File: rtl/crc_pkg.sv
package crc_pkg;
    typedef enum logic [2:0] {
        CM_IDLE   = 3'b000,
        CM_RISE   = 3'b001,
        CM_BOTH   = 3'b010,
        CM_GATED  = 3'b011,
        CM_QUAD   = 3'b100,
        CM_SECDIR = 3'b101,
        CM_TRIG   = 3'b110,
        CM_CASC   = 3'b111
    } cmode_e;

    typedef struct packed {
        logic a;
        logic b;
    } qtrk_t;
endpackage

// File: rtl/crc_step.sv
module crc_step
    import crc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       dir_i,
    input  logic       prim_rise_i,
    input  logic       prim_fall_i,
    input  logic       prim_lvl_i,
    input  logic       sec_lvl_i,
    input  logic       sec_rise_i,
    output logic       step_o,
    output logic       down_o,
    output logic       trig_o
);
    cmode_e mode;
    qtrk_t  trk_d, trk_q;
    logic   q_step, q_down;

    assign mode = cmode_e'(mode_i);

    always_comb begin
        trk_d.a = prim_lvl_i;
        trk_d.b = sec_lvl_i;
        // exactly one input changed: a valid Gray transition
        q_step  = (prim_lvl_i ^ trk_q.a) ^ (sec_lvl_i ^ trk_q.b);
        q_down  = trk_q.a ^ sec_lvl_i;
    end

    always_comb begin
        step_o = 1'b0;
        down_o = dir_i;
        trig_o = 1'b0;
        case (mode)
            CM_IDLE:   step_o = 1'b0;
            CM_RISE:   step_o = prim_rise_i;
            CM_BOTH:   step_o = prim_rise_i | prim_fall_i;
            CM_GATED:  step_o = prim_rise_i & sec_lvl_i;
            CM_QUAD: begin
                step_o = q_step;
                down_o = q_step ? q_down : dir_i;
            end
            CM_SECDIR: begin
                step_o = prim_rise_i;
                down_o = dir_i ^ sec_lvl_i;
            end
            CM_TRIG: begin
                step_o = prim_rise_i;
                trig_o = sec_rise_i;
            end
            CM_CASC: begin
                step_o = prim_rise_i ^ prim_fall_i;
                down_o = prim_fall_i;
            end
            default: step_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end
endmodule

// File: rtl/crc_core.sv
module crc_core
    import crc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig_mode_i,
    input  logic         len_i,
    input  logic         once_i,
    input  logic         alt_cmp_i,
    input  logic         tci_i,
    input  logic         alt_load_i,
    input  logic         step_i,
    input  logic         down_i,
    input  logic         trig_i,
    input  logic [W-1:0] comp1_i,
    input  logic [W-1:0] comp2_i,
    input  logic [W-1:0] load_i,
    input  logic [W-1:0] alt_val_i,
    input  logic         ext_reload_i,
    input  logic         ovf_clr_i,
    input  logic         cmpf_clr_i,
    output logic [W-1:0] count_o,
    output logic         cmp1_o,
    output logic         cmp2_o,
    output logic         ovf_o,
    output logic         cmpf_o,
    output logic         up_o
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         phase;
        logic         halted;
        logic         running;
        logic         up;
        logic         ovf;
        logic         cmpf;
        logic         c1;
        logic         c2;
    } st_t;

    st_t          st_d, st_q;
    logic         live_step;
    logic [W-1:0] reload_val;
    logic [W-1:0] target;
    logic         hit, hit_is2;

    always_comb begin
        live_step  = step_i & ~st_q.halted & (~trig_mode_i | st_q.running);
        reload_val = (alt_load_i & down_i) ? alt_val_i : load_i;
        hit_is2    = alt_cmp_i ? st_q.phase : down_i;
        target     = hit_is2 ? comp2_i : comp1_i;
        hit        = live_step & (st_q.cnt == target);

        st_d      = st_q;
        st_d.c1   = 1'b0;
        st_d.c2   = 1'b0;
        st_d.ovf  = st_q.ovf & ~ovf_clr_i;
        st_d.cmpf = st_q.cmpf & ~cmpf_clr_i;

        if (ext_reload_i) begin
            st_d.cnt     = reload_val;
            st_d.phase   = 1'b0;
            st_d.halted  = 1'b0;
            st_d.running = 1'b0;
        end else if (trig_mode_i && trig_i && st_q.running) begin
            if (tci_i) st_d.cnt     = reload_val;
            else       st_d.running = 1'b0;
        end else begin
            if (trig_mode_i && trig_i) st_d.running = 1'b1;
            if (live_step) begin
                st_d.up = ~down_i;
                if (hit && len_i) begin
                    st_d.cnt = reload_val;
                end else if (down_i) begin
                    st_d.cnt = st_q.cnt - ONE;
                    if (st_q.cnt == '0) st_d.ovf = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                    if (st_q.cnt == ALL_ONES) st_d.ovf = 1'b1;
                end
                if (hit) begin
                    st_d.cmpf = 1'b1;
                    st_d.c1   = ~hit_is2;
                    st_d.c2   = hit_is2;
                    if (alt_cmp_i) st_d.phase = ~st_q.phase;
                    if (once_i && (!alt_cmp_i || st_q.phase)) st_d.halted = 1'b1;
                    if (trig_mode_i) st_d.running = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.up <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign cmp1_o  = st_q.c1;
    assign cmp2_o  = st_q.c2;
    assign ovf_o   = st_q.ovf;
    assign cmpf_o  = st_q.cmpf;
    assign up_o    = st_q.up;
endmodule

// File: rtl/cmp_reload_ctr.sv
module cmp_reload_ctr
    import crc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   mode_i,
    input  logic         dir_i,
    input  logic         len_i,
    input  logic         once_i,
    input  logic         alt_cmp_i,
    input  logic         tci_i,
    input  logic         alt_load_i,
    input  logic         prim_rise_i,
    input  logic         prim_fall_i,
    input  logic         prim_lvl_i,
    input  logic         sec_lvl_i,
    input  logic         sec_rise_i,
    input  logic [W-1:0] comp1_i,
    input  logic [W-1:0] comp2_i,
    input  logic [W-1:0] load_i,
    input  logic [W-1:0] alt_val_i,
    input  logic         ext_reload_i,
    input  logic         ovf_clr_i,
    input  logic         cmpf_clr_i,
    output logic [W-1:0] count_o,
    output logic         cmp1_o,
    output logic         cmp2_o,
    output logic         ovf_o,
    output logic         cmpf_o,
    output logic         up_o
);
    logic step, down, trig, trig_mode;

    assign trig_mode = (cmode_e'(mode_i) == CM_TRIG);

    crc_step i_step (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .dir_i       (dir_i),
        .prim_rise_i (prim_rise_i),
        .prim_fall_i (prim_fall_i),
        .prim_lvl_i  (prim_lvl_i),
        .sec_lvl_i   (sec_lvl_i),
        .sec_rise_i  (sec_rise_i),
        .step_o      (step),
        .down_o      (down),
        .trig_o      (trig)
    );

    crc_core #(.W(W)) i_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_mode_i  (trig_mode),
        .len_i        (len_i),
        .once_i       (once_i),
        .alt_cmp_i    (alt_cmp_i),
        .tci_i        (tci_i),
        .alt_load_i   (alt_load_i),
        .step_i       (step),
        .down_i       (down),
        .trig_i       (trig),
        .comp1_i      (comp1_i),
        .comp2_i      (comp2_i),
        .load_i       (load_i),
        .alt_val_i    (alt_val_i),
        .ext_reload_i (ext_reload_i),
        .ovf_clr_i    (ovf_clr_i),
        .cmpf_clr_i   (cmpf_clr_i),
        .count_o      (count_o),
        .cmp1_o       (cmp1_o),
        .cmp2_o       (cmp2_o),
        .ovf_o        (ovf_o),
        .cmpf_o       (cmpf_o),
        .up_o         (up_o)
    );
endmodule

// File: rtl/crc_chk.sv
module crc_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   mode_i,
    input logic         alt_load_i,
    input logic [W-1:0] load_i,
    input logic         ext_reload_i,
    input logic         ovf_clr_i,
    input logic         cmpf_clr_i,
    input logic [W-1:0] count_o,
    input logic         cmp1_o,
    input logic         cmp2_o,
    input logic         ovf_o,
    input logic         cmpf_o
);
    // R14
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);
    // R14
    cmpf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpf_o && !cmpf_clr_i) |=> cmpf_o);
    // R14
    cmpf_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp1_o || cmp2_o) |-> cmpf_o);
    // R5
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmp1_o, cmp2_o}));
    // R13
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_reload_i && !alt_load_i) |=> (count_o == $past(load_i)));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'b000 && !ext_reload_i) |=> $stable(count_o));
endmodule

bind cmp_reload_ctr crc_chk #(.W(W)) i_chk (.*);

// File: tb/test_cmp_reload_ctr.sv
module test_cmp_reload_ctr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'b001;
    logic        dir = 0, len = 0, once = 0, alt_cmp = 0, tci = 0, alt_ld = 0;
    logic        p_rise = 0, p_fall = 0, p_lvl = 0, s_lvl = 0, s_rise = 0;
    logic [15:0] comp1 = 16'h0003, comp2 = 16'h8000, ld = 16'h0000, ald = 16'h0000;
    logic        reload = 0, ovf_clr = 0, cmpf_clr = 0;
    logic [15:0] count;
    logic        c1, c2, ovf, cmpf, up;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [15:0] cnt;
        logic        e1, e2, eo, ef, eu;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    cmp_reload_ctr i_cmp_reload_ctr (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .dir_i(dir), .len_i(len),
        .once_i(once), .alt_cmp_i(alt_cmp), .tci_i(tci), .alt_load_i(alt_ld),
        .prim_rise_i(p_rise), .prim_fall_i(p_fall), .prim_lvl_i(p_lvl),
        .sec_lvl_i(s_lvl), .sec_rise_i(s_rise), .comp1_i(comp1), .comp2_i(comp2),
        .load_i(ld), .alt_val_i(ald), .ext_reload_i(reload), .ovf_clr_i(ovf_clr),
        .cmpf_clr_i(cmpf_clr), .count_o(count), .cmp1_o(c1), .cmp2_o(c2),
        .ovf_o(ovf), .cmpf_o(cmpf), .up_o(up)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (count !== e.cnt || c1 !== e.e1 || c2 !== e.e2 || ovf !== e.eo ||
            cmpf !== e.ef || up !== e.eu) begin
            fails++;
            $display("FAIL %s: got cnt=%h c1=%b c2=%b ovf=%b cmpf=%b up=%b, expected cnt=%h c1=%b c2=%b ovf=%b cmpf=%b up=%b",
                     e.tag, count, c1, c2, ovf, cmpf, up, e.cnt, e.e1, e.e2, e.eo, e.ef, e.eu);
        end
    endtask

    // monitor: one queued expectation per cycle, one time unit after the edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) compare(sb.pop_front());
    end

    // driver: inputs already set at a falling edge; queue expectation, advance
    task automatic tick(input logic [15:0] ec, input logic e1, input logic e2,
                        input logic eo, input logic ef, input logic eu, input string tag);
        exp_t e;
        e.cnt = ec; e.e1 = e1; e.e2 = e2; e.eo = eo; e.ef = ef; e.eu = eu; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        p_rise = 0; p_fall = 0; s_rise = 0; reload = 0; ovf_clr = 0; cmpf_clr = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        begin
            exp_t e;
            e.cnt = 16'h0; e.e1 = 0; e.e2 = 0; e.eo = 0; e.ef = 0; e.eu = 1; e.tag = "R1 reset";
            compare(e);
        end
        // R3 / R7: count up to comp1 and reinitialise
        len = 1;
        p_rise = 1; tick(16'h1, 0, 0, 0, 0, 1, "R7 mode 001 step");
        p_rise = 1; tick(16'h2, 0, 0, 0, 0, 1, "R3 up");
        p_rise = 1; tick(16'h3, 0, 0, 0, 0, 1, "R3 reach comp1");
        p_rise = 1; tick(16'h0, 1, 0, 0, 1, 1, "R3 reinit + cmp1 pulse");
        tick(16'h0, 0, 0, 0, 1, 1, "R3 pulse one cycle");
        mode = 3'b000; p_rise = 1; tick(16'h0, 0, 0, 0, 1, 1, "R7 mode 000 idle");
        mode = 3'b001; p_fall = 1; tick(16'h0, 0, 0, 0, 1, 1, "R7 mode 001 ignores fall");
        mode = 3'b010; p_fall = 1; tick(16'h1, 0, 0, 0, 1, 1, "R7 mode 010 fall");
        mode = 3'b011; p_rise = 1; tick(16'h1, 0, 0, 0, 1, 1, "R7 mode 011 gated off");
        s_lvl = 1; p_rise = 1; tick(16'h2, 0, 0, 0, 1, 1, "R7 mode 011 gated on");
        s_lvl = 0; mode = 3'b001; cmpf_clr = 1; tick(16'h2, 0, 0, 0, 0, 1, "R14 cmpf clear");
        // R13 reload priority
        ld = 16'h0100; reload = 1; p_rise = 1; tick(16'h0100, 0, 0, 0, 0, 1, "R13 reload beats step");
        // R2 wraps
        len = 0; ld = 16'hFFFE; reload = 1; tick(16'hFFFE, 0, 0, 0, 0, 1, "R13 reload");
        p_rise = 1; tick(16'hFFFF, 0, 0, 0, 0, 1, "R2 up");
        p_rise = 1; tick(16'h0000, 0, 0, 1, 0, 1, "R2 up wrap");
        dir = 1; p_rise = 1; tick(16'hFFFF, 0, 0, 1, 0, 0, "R12 down step");
        ovf_clr = 1; tick(16'hFFFF, 0, 0, 0, 0, 0, "R14 ovf clear");
        ld = 16'h0000; reload = 1; tick(16'h0000, 0, 0, 0, 0, 0, "R2 reload 0");
        p_rise = 1; tick(16'hFFFF, 0, 0, 1, 0, 0, "R2 down wrap");
        tick(16'hFFFF, 0, 0, 1, 0, 0, "R14 ovf sticky");
        // R4 down compare
        ld = 16'hFFFF; reload = 1; ovf_clr = 1; tick(16'hFFFF, 0, 0, 0, 0, 0, "R4 setup");
        len = 1; comp2 = 16'hFFFD; ld = 16'h0005;
        p_rise = 1; tick(16'hFFFE, 0, 0, 0, 0, 0, "R4 down");
        p_rise = 1; tick(16'hFFFD, 0, 0, 0, 0, 0, "R4 reach comp2");
        p_rise = 1; tick(16'h0005, 0, 1, 0, 1, 0, "R4 reinit + cmp2 pulse");
        // R11 alternate reload value
        alt_ld = 1; ald = 16'h0040; comp2 = 16'h0004;
        p_rise = 1; tick(16'h0004, 0, 0, 0, 1, 0, "R11 down");
        p_rise = 1; tick(16'h0040, 0, 1, 0, 1, 0, "R11 down uses alternate");
        dir = 0; comp1 = 16'h0042;
        p_rise = 1; tick(16'h0041, 0, 0, 0, 1, 1, "R12 up again");
        p_rise = 1; tick(16'h0042, 0, 0, 0, 1, 1, "R11 up");
        p_rise = 1; tick(16'h0005, 1, 0, 0, 1, 1, "R11 up uses load");
        alt_ld = 0;
        // R5 alternating compare
        alt_cmp = 1; comp1 = 16'h0002; comp2 = 16'h0001; ld = 16'h0000;
        reload = 1; cmpf_clr = 1; tick(16'h0, 0, 0, 0, 0, 1, "R5 setup");
        p_rise = 1; tick(16'h1, 0, 0, 0, 0, 1, "R5 step");
        p_rise = 1; tick(16'h2, 0, 0, 0, 0, 1, "R5 pass comp2 value in phase 1");
        p_rise = 1; tick(16'h0, 1, 0, 0, 1, 1, "R5 hit comp1");
        p_rise = 1; tick(16'h1, 0, 0, 0, 1, 1, "R5 step");
        p_rise = 1; tick(16'h0, 0, 1, 0, 1, 1, "R5 hit comp2");
        p_rise = 1; tick(16'h1, 0, 0, 0, 1, 1, "R5 step");
        p_rise = 1; tick(16'h2, 0, 0, 0, 1, 1, "R5 step");
        p_rise = 1; tick(16'h0, 1, 0, 0, 1, 1, "R5 hit comp1 again");
        // R6 once
        alt_cmp = 0; once = 1; reload = 1; tick(16'h0, 0, 0, 0, 1, 1, "R6 setup");
        p_rise = 1; tick(16'h1, 0, 0, 0, 1, 1, "R6 step");
        p_rise = 1; tick(16'h2, 0, 0, 0, 1, 1, "R6 step");
        p_rise = 1; tick(16'h0, 1, 0, 0, 1, 1, "R6 compare");
        p_rise = 1; tick(16'h0, 0, 0, 0, 1, 1, "R6 halted");
        alt_cmp = 1; reload = 1; tick(16'h0, 0, 0, 0, 1, 1, "R6 release by reload");
        p_rise = 1; tick(16'h1, 0, 0, 0, 1, 1, "R6 alt step");
        p_rise = 1; tick(16'h2, 0, 0, 0, 1, 1, "R6 alt step");
        p_rise = 1; tick(16'h0, 1, 0, 0, 1, 1, "R6 alt comp1 continues");
        p_rise = 1; tick(16'h1, 0, 0, 0, 1, 1, "R6 alt step");
        p_rise = 1; tick(16'h0, 0, 1, 0, 1, 1, "R6 alt comp2");
        p_rise = 1; tick(16'h0, 0, 0, 0, 1, 1, "R6 alt halted");
        once = 0; alt_cmp = 0;
        // R8 quadrature
        mode = 3'b100; len = 0; ld = 16'h0010; reload = 1; cmpf_clr = 1;
        tick(16'h0010, 0, 0, 0, 0, 1, "R8 setup");
        p_lvl = 1; s_lvl = 0; tick(16'h0011, 0, 0, 0, 0, 1, "R8 00->10 up");
        p_lvl = 1; s_lvl = 1; tick(16'h0012, 0, 0, 0, 0, 1, "R8 10->11 up");
        p_lvl = 0; s_lvl = 1; tick(16'h0013, 0, 0, 0, 0, 1, "R8 11->01 up");
        p_lvl = 0; s_lvl = 0; tick(16'h0014, 0, 0, 0, 0, 1, "R8 01->00 up");
        p_lvl = 0; s_lvl = 1; tick(16'h0013, 0, 0, 0, 0, 0, "R8 00->01 down");
        p_lvl = 1; s_lvl = 0; tick(16'h0013, 0, 0, 0, 0, 0, "R8 double change ignored");
        tick(16'h0013, 0, 0, 0, 0, 0, "R8 no change holds");
        // R9 secondary direction and cascade
        mode = 3'b101; p_lvl = 0; s_lvl = 0; ld = 16'h0020; reload = 1;
        tick(16'h0020, 0, 0, 0, 0, 0, "R9 setup");
        p_rise = 1; tick(16'h0021, 0, 0, 0, 0, 1, "R9 sec low up");
        s_lvl = 1; p_rise = 1; tick(16'h0020, 0, 0, 0, 0, 0, "R9 sec high down");
        s_lvl = 0; mode = 3'b111;
        p_rise = 1; tick(16'h0021, 0, 0, 0, 0, 1, "R9 cascade up");
        p_fall = 1; tick(16'h0020, 0, 0, 0, 0, 0, "R9 cascade down");
        // R10 triggered
        mode = 3'b110; len = 1; comp1 = 16'h0024; tci = 0; reload = 1;
        tick(16'h0020, 0, 0, 0, 0, 0, "R10 setup");
        p_rise = 1; tick(16'h0020, 0, 0, 0, 0, 0, "R10 no run no count");
        s_rise = 1; tick(16'h0020, 0, 0, 0, 0, 0, "R10 trigger");
        p_rise = 1; tick(16'h0021, 0, 0, 0, 0, 1, "R10 running");
        p_rise = 1; tick(16'h0022, 0, 0, 0, 0, 1, "R10 running");
        s_rise = 1; tick(16'h0022, 0, 0, 0, 0, 1, "R10 second trigger stops");
        p_rise = 1; tick(16'h0022, 0, 0, 0, 0, 1, "R10 stopped");
        s_rise = 1; tick(16'h0022, 0, 0, 0, 0, 1, "R10 restart");
        p_rise = 1; tick(16'h0023, 0, 0, 0, 0, 1, "R10 running");
        p_rise = 1; tick(16'h0024, 0, 0, 0, 0, 1, "R10 running");
        p_rise = 1; tick(16'h0020, 1, 0, 0, 1, 1, "R10 compare ends run");
        p_rise = 1; tick(16'h0020, 0, 0, 0, 1, 1, "R10 idle after compare");
        tci = 1; s_rise = 1; tick(16'h0020, 0, 0, 0, 1, 1, "R10 trigger");
        p_rise = 1; tick(16'h0021, 0, 0, 0, 1, 1, "R10 running");
        s_rise = 1; tick(16'h0020, 0, 0, 0, 1, 1, "R10 second trigger reloads");
        p_rise = 1; tick(16'h0021, 0, 0, 0, 1, 1, "R10 still running");
        @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule